// File: doc/BRIEF.md
# Step-Adjusted Pulse-Width Modulator

This block drives a single pulse-width-modulated output at a fixed rate. Each output period lasts ten clocks, so a 100 MHz clock gives a 10 MHz waveform. The high time is set in tenths of the period.

Two single-bit request lines adjust the high time while the block runs. A rising edge on the raise line adds one tenth. A rising edge on the lower line removes one tenth. The setting starts at five tenths after reset and is held between one and nine tenths.

Both request lines are synchronised inside the block, and each one goes through an edge detector. A request held for many clocks therefore counts as a single step. A new setting takes effect only at the start of the next period, so the period in progress is never cut short or stretched.

Top module: `step_pwm_top`

## Requirements
- R1: The output is periodic with a period of exactly 10 clocks, and every period begins with the output high.
- R2: While reset is asserted the output is high, and the first periods after reset are high for 5 clocks and low for 5 clocks.
- R3: Within each period, the output is high for the first D clocks and low for the remaining 10-D clocks, where D is the active setting.
- R4: Each low-to-high transition of `raise_req` increases D by exactly one, however long the line stays high.
- R5: Each low-to-high transition of `lower_req` decreases D by exactly one, however long the line stays high.
- R6: A raise request while D is 9 leaves D at 9.
- R7: A lower request while D is 1 leaves D at 1.
- R8: When rising edges on `raise_req` and `lower_req` are detected in the same clock, D is left unchanged.
- R9: A changed setting is applied only from the next period start. The period in which a request arrives keeps its previous high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; 100 MHz gives a 10 MHz output |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, internal release is synchronised |
| raise_req | input | 1 | Asynchronous request to increase the high time by one tenth, acting on its rising edge |
| lower_req | input | 1 | Asynchronous request to decrease the high time by one tenth, acting on its rising edge |
| pwm_out | output | 1 | Modulated output |

## Verification
A fault in the period counter shows at the port within one period, as a spacing between rising edges that is not ten clocks. A fault in the duty register or in its saturation shows at the next period start, as a high run of the wrong length. An edge detector that re-triggers while a request is held shows after a long press, as a high time that has moved by more than one step. Applying a new setting too early shows as a high run of the wrong length in the period where the request lands. The bench counts high runs between output rising edges, so every one of these faults is seen within two periods of its cause.

// File: rtl/step_pwm_pkg.sv
`timescale 1ns/1ps
package step_pwm_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_RAISE = 2'd1,
    CMD_LOWER = 2'd2
  } step_cmd_e;

  // Opposing requests in the same cycle cancel out.
  function automatic step_cmd_e decode_cmd(input logic up, input logic dn);
    step_cmd_e cmd;
    case ({up, dn})
      2'b10:   cmd = CMD_RAISE;
      2'b01:   cmd = CMD_LOWER;
      default: cmd = CMD_HOLD;
    endcase
    return cmd;
  endfunction

endpackage

// File: rtl/req_sync_edge.sv
`timescale 1ns/1ps
module req_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic rise_pulse
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d[0] = req_async;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~last_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R4

endmodule

// File: rtl/period_counter.sv
`timescale 1ns/1ps
module period_counter #(
  parameter int STEPS = 10,
  localparam int CW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count,
  output logic          wrap
);

  logic [CW-1:0] count_d;

  assign wrap = (count == CW'(STEPS - 1));

  always_comb begin
    if (wrap) count_d = '0;
    else      count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count < CW'(STEPS)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0)); // R1
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (count == $past(count) + 1'b1)); // R1

endmodule

// File: rtl/duty_stepper.sv
`timescale 1ns/1ps
module duty_stepper
  import step_pwm_pkg::*;
#(
  parameter int STEPS      = 10,
  parameter int DUTY_RESET = 5,
  parameter int DUTY_MIN   = 1,
  parameter int DUTY_MAX   = 9,
  localparam int CW        = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise_evt,
  input  logic          lower_evt,
  input  logic          wrap,
  output logic [CW-1:0] duty_act
);

  localparam logic [CW-1:0] D_RST = CW'(DUTY_RESET);
  localparam logic [CW-1:0] D_MIN = CW'(DUTY_MIN);
  localparam logic [CW-1:0] D_MAX = CW'(DUTY_MAX);

  step_cmd_e     cmd;
  logic [CW-1:0] pend_q, pend_d;
  logic [CW-1:0] act_d;
  logic          pend_en;

  assign cmd = decode_cmd(raise_evt, lower_evt);

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    case (cmd)
      CMD_RAISE: if (pend_q < D_MAX) begin
        pend_d  = pend_q + 1'b1;
        pend_en = 1'b1;
      end
      CMD_LOWER: if (pend_q > D_MIN) begin
        pend_d  = pend_q - 1'b1;
        pend_en = 1'b1;
      end
      default: ;
    endcase
    act_d = wrap ? pend_q : duty_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= D_RST;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_act <= D_RST;
    else        duty_act <= act_d;
  end

  AST_DUTY_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q >= D_MIN) && (pend_q <= D_MAX)); // R6 R7
  AST_DUTY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pend_q) || (pend_q == $past(pend_q) + 1'b1) || (pend_q + 1'b1 == $past(pend_q))); // R4 R5
  AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_evt && lower_evt) |=> $stable(pend_q)); // R8
  AST_APPLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(duty_act)); // R9

endmodule

// File: rtl/step_pwm_top.sv
`timescale 1ns/1ps
module step_pwm_top #(
  parameter int STEPS       = 10,
  parameter int DUTY_RESET  = 5,
  parameter int DUTY_MIN    = 1,
  parameter int DUTY_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_req,
  input  logic lower_req,
  output logic pwm_out
);

  localparam int CW = $clog2(STEPS);

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [1:0]    req_vec;
  logic [1:0]    evt_vec;
  logic [CW-1:0] count;
  logic          wrap;
  logic [CW-1:0] duty_act;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign req_vec = {lower_req, raise_req};

  for (genvar g = 0; g < 2; g++) begin : g_req
    req_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .req_async  (req_vec[g]),
      .rise_pulse (evt_vec[g])
    );
  end

  period_counter #(.STEPS(STEPS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .count (count),
    .wrap  (wrap)
  );

  duty_stepper #(
    .STEPS      (STEPS),
    .DUTY_RESET (DUTY_RESET),
    .DUTY_MIN   (DUTY_MIN),
    .DUTY_MAX   (DUTY_MAX)
  ) u_duty (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .raise_evt (evt_vec[0]),
    .lower_evt (evt_vec[1]),
    .wrap      (wrap),
    .duty_act  (duty_act)
  );

  assign pwm_out = (count < duty_act);

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (count == '0) |-> pwm_out); // R3
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |-> !pwm_out); // R3

endmodule

// File: tb/step_pwm_top_tb_top.sv
`timescale 1ns/1ps
module step_pwm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic raise_req;
  logic lower_req;
  logic pwm_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_pwm_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_req (raise_req),
    .lower_req (lower_req),
    .pwm_out   (pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pattern_of(input int d);
    logic [9:0] p;
    for (int i = 0; i < 10; i++) p[i] = (i < d);
    return p;
  endfunction

  // Wait for an output rising edge; on return the sample at the start of a period has just been taken.
  task automatic find_start();
    logic prev;
    bit   hit;
    prev = pwm_out;
    hit  = 1'b0;
    for (int i = 0; i < 40 && !hit; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) hit = 1'b1;
      prev = pwm_out;
    end
    check(hit, "R1 rising edge found", int'(hit), 1);
  endtask

  task automatic collect_rest(inout logic [9:0] pat);
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      pat[i] = pwm_out;
    end
  endtask

  // R3: one period has the expected high run; R1: the next period starts high, ten clocks later.
  task automatic verify_duty(input int d, input string req);
    logic [9:0] pat;
    find_start();
    pat = '0;
    pat[0] = pwm_out;
    collect_rest(pat);
    check(pat == pattern_of(d), req, int'(pat), int'(pattern_of(d)));
    @(negedge clk);
    check(pwm_out == 1'b1, "R1 period of ten", int'(pwm_out), 1);
  endtask

  task automatic press(input logic up, input logic dn, input int hold);
    @(negedge clk);
    raise_req = up;
    lower_req = dn;
    repeat (hold) @(negedge clk);
    raise_req = 1'b0;
    lower_req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    raise_req = 1'b0;
    lower_req = 1'b0;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b1, "R2 output high in reset", int'(pwm_out), 1);
    rst_n = 1'b1;
    verify_duty(5, "R2 reset setting five tenths");
    verify_duty(5, "R3 steady five tenths");
  endtask

  task automatic t_raise();
    press(1'b1, 1'b0, 1);
    verify_duty(6, "R4 short raise");
    press(1'b1, 1'b0, 30);
    verify_duty(7, "R4 long raise steps once");
  endtask

  task automatic t_lower();
    press(1'b0, 1'b1, 3);
    verify_duty(6, "R5 lower one step");
    press(1'b0, 1'b1, 25);
    verify_duty(5, "R5 long lower steps once");
    press(1'b1, 1'b0, 2);
    verify_duty(6, "R4 raise back");
  endtask

  task automatic t_both();
    press(1'b1, 1'b1, 4);
    verify_duty(6, "R8 simultaneous edges ignored");
  endtask

  task automatic t_upper_limit();
    for (int k = 0; k < 5; k++) press(1'b1, 1'b0, 2);
    verify_duty(9, "R6 saturate at nine");
  endtask

  task automatic t_mid_period();
    logic [9:0] pat;
    find_start();
    pat = '0;
    pat[0] = pwm_out;
    lower_req = 1'b1;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      pat[i] = pwm_out;
      if (i == 3) lower_req = 1'b0;
    end
    check(pat == pattern_of(9), "R9 current period keeps width", int'(pat), int'(pattern_of(9)));
    verify_duty(8, "R9 new width next period");
  endtask

  task automatic t_lower_limit();
    for (int k = 0; k < 10; k++) press(1'b0, 1'b1, 2);
    verify_duty(1, "R7 saturate at one");
    press(1'b1, 1'b0, 2);
    verify_duty(2, "R7 raise from floor");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_raise();
    t_lower();
    t_both();
    t_upper_limit();
    t_mid_period();
    t_lower_limit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule